// File: doc/BRIEF.md
# Padded Long Block-Move Engine

This sequential engine copies a byte string from a source region to a destination region. Both regions live in a 24-bit address space that wraps from the top address back to zero. The destination may be longer than the source. In that case, once the source is used up, the remaining destination bytes are filled with a pad byte. The engine takes four 32-bit register images when `start` is pulsed:

- the destination start address
- the destination byte count
- the source start address
- the source byte count, with the pad byte in its top byte

Before it moves any data, the engine compares the two lengths to form a 2-bit condition code. It also checks whether the copy would overwrite source bytes before they are read. If it would, nothing moves.

Memory is reached through a byte-wide request/acknowledge port. A source byte costs one read and one write. A pad byte costs only a write. An interrupt request is honoured only after a completed byte store. When it is taken, the engine stops and hands back updated register images. Feeding those images back in with a new `start` finishes the move.

Top module: `lbm_engine`

## Requirements
- R1: Addresses and lengths are taken from bits 23:0 of their 32-bit inputs. The pad byte is bits 31:24 of the source-length input. The top bytes of the two address inputs and of the destination-length input never affect the move.
- R2: When no destructive overlap exists, `cc` reports the length comparison: 0 when the lengths are equal, 1 when the destination length is the smaller, and 2 when it is the larger.
- R3: Destructive overlap exists when the destination start lies on one of the participating source bytes other than the first one. In that case `cc` is 3 and no memory request is made. The length outputs equal their inputs, and the address outputs equal their inputs with bits 31:24 cleared.
- R4: The participating source span is min(destination length, source length). A span of 0 or 1 never counts as destructive overlap, and neither does a destination start equal to the source start.
- R5: The overlap test treats the address space as circular. Bytes just below the wrap point count as lying before bytes at low addresses.
- R6: A destination length of zero makes no memory request. It still sets `cc` by R2 and clears bits 31:24 of both address outputs.
- R7: Destination byte i (i from 0 upward) receives source byte i while i is below the source length, and the pad byte otherwise. Byte addresses advance by one and wrap from 0xFFFFFF to 0. One read precedes each copied byte's write, and pad bytes are written without any read.
- R8: At completion, `done` pulses for one cycle. The destination address output is advanced by the bytes stored and its length output reads zero. The source address output is advanced, and its length output reduced, by the bytes copied. Address outputs have bits 31:24 at zero, and length outputs keep their input bits 31:24.
- R9: `irq_req` is sampled only after a completed byte store, and only while destination bytes remain. When it is taken, `paused` pulses for one cycle (never together with `done`) with the partial register images on the outputs. Restarting from those images produces the same final memory and registers as an uninterrupted move.
- R10: When the interrupt is taken during padding, the source length output is zero and the source address output is the original source address plus the original source length.
- R11: A memory request holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`, and no request is made while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a move (taken while idle) |
| dst_addr_i | input | 32 | Destination address register image |
| dst_len_i | input | 32 | Destination length register image |
| src_addr_i | input | 32 | Source address register image |
| src_len_i | input | 32 | Pad byte (31:24) and source length |
| irq_req | input | 1 | Interrupt request, sampled after each store |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle pulse: move finished |
| paused | output | 1 | One-cycle pulse: move stopped for an interrupt |
| cc | output | 2 | Condition code |
| dst_addr_o | output | 32 | Updated destination address image |
| dst_len_o | output | 32 | Updated destination length image |
| src_addr_o | output | 32 | Updated source address image |
| src_len_o | output | 32 | Updated pad and source length image |

## Verification
The hardest state to reach is an interrupt taken in the middle of the pad phase, followed by a resume from the returned images. The bench counts write acknowledges at the memory port and raises `irq_req` in the half cycle after a chosen store completes. This lands the stop at a known byte count past the end of the source. Destructive overlap across the wrap point is reached by placing the source just below 0xFFFFFF and the destination just above zero. The bench's memory aliases those addresses onto a small array, so the wrapped bytes stay visible.

// File: rtl/lbm_pkg.sv
// Shared definitions for the padded long block-move engine.
// Assumes: condition-code encodings are fixed by the register contract.
package lbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_NEXT,
        ST_FIN
    } lbm_state_t;

    localparam logic [1:0] CC_EQUAL     = 2'd0;
    localparam logic [1:0] CC_DST_SHORT = 2'd1;
    localparam logic [1:0] CC_DST_LONG  = 2'd2;
    localparam logic [1:0] CC_OVERLAP   = 2'd3;

endpackage

// File: rtl/lbm_cursor.sv
// One operand cursor: an address that counts up with wrap and a length
// that counts down. Loaded at start, stepped once per consumed byte.
// Assumes: step is never asserted while the length is zero.
module lbm_cursor #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] len_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] len_q,
    output logic              empty
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Hold, reload or advance the cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
        end else if (load) begin
            addr_q <= addr_i;
            len_q  <= len_i;
        end else if (step) begin
            addr_q <= addr_q + ONE;
            len_q  <= len_q - ONE;
        end
    end

    // Flag an exhausted operand.
    always_comb begin
        empty = (len_q == '0);
    end

endmodule

// File: rtl/lbm_overlap.sv
// Pre-move decision logic: length comparison code and destructive-overlap
// detection on a circular address space.
// Assumes: inputs are the freshly loaded cursor values (stable in CHECK).
module lbm_overlap #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [ADDR_W-1:0] dst_len,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] src_len,
    output logic [1:0]        cc_len,
    output logic              destructive
);
    import lbm_pkg::*;

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] offset;

    // Compare lengths for the condition code.
    always_comb begin
        if (dst_len == src_len)     cc_len = CC_EQUAL;
        else if (dst_len < src_len) cc_len = CC_DST_SHORT;
        else                        cc_len = CC_DST_LONG;
    end

    // Circular distance from source start to destination start; the move
    // is destructive when that distance lands inside (0, span).
    always_comb begin
        span        = (dst_len < src_len) ? dst_len : src_len;
        offset      = dst_addr - src_addr;
        destructive = (span > ONE) && (offset != '0) && (offset < span);
    end

endmodule

// File: rtl/lbm_ctrl.sv
// Sequencer for the block move: decide, then loop read/write per byte,
// sampling the interrupt request only after each completed store.
// Assumes: mem_ack is only returned while mem_req is high.
module lbm_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       irq_req,
    input  logic       mem_ack,
    input  logic       dst_empty,
    input  logic       src_empty,
    input  logic       destructive,
    input  logic [1:0] cc_len,
    output logic       load,
    output logic       dst_step,
    output logic       src_step,
    output logic       capture,
    output logic       from_src,
    output logic       mem_req,
    output logic       mem_we,
    output logic       busy,
    output logic       done,
    output logic       paused,
    output logic [1:0] cc
);
    import lbm_pkg::*;

    lbm_state_t state;
    logic       stop_irq;

    // State sequencing, byte-kind selection and result code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            from_src <= 1'b0;
            stop_irq <= 1'b0;
            cc       <= CC_EQUAL;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) state <= ST_CHECK;
                end
                ST_CHECK: begin
                    stop_irq <= 1'b0;
                    if (destructive) begin
                        cc    <= CC_OVERLAP;
                        state <= ST_FIN;
                    end else begin
                        cc <= cc_len;
                        if (dst_empty) begin
                            state <= ST_FIN;
                        end else if (!src_empty) begin
                            from_src <= 1'b1;
                            state    <= ST_READ;
                        end else begin
                            from_src <= 1'b0;
                            state    <= ST_WRITE;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) state <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (mem_ack) state <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (dst_empty) begin
                        state <= ST_FIN;
                    end else if (irq_req) begin
                        stop_irq <= 1'b1;
                        state    <= ST_FIN;
                    end else if (!src_empty) begin
                        from_src <= 1'b1;
                        state    <= ST_READ;
                    end else begin
                        from_src <= 1'b0;
                        state    <= ST_WRITE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Decode state into strobes and memory controls.
    always_comb begin
        load     = (state == ST_IDLE) && start;
        mem_req  = (state == ST_READ) || (state == ST_WRITE);
        mem_we   = (state == ST_WRITE);
        capture  = (state == ST_READ) && mem_ack;
        dst_step = (state == ST_WRITE) && mem_ack;
        src_step = dst_step && from_src;
        busy     = (state != ST_IDLE);
        done     = (state == ST_FIN) && !stop_irq;
        paused   = (state == ST_FIN) && stop_irq;
    end

endmodule

// File: rtl/lbm_engine.sv
// Top of the padded long block-move engine. Splits the register images,
// drives two operand cursors, the overlap decision and the sequencer, and
// rebuilds the register images for completion or resumption.
// Assumes: REG_W - ADDR_W equals BYTE_W (the pad byte fills the top byte).
module lbm_engine #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  dst_addr_i,
    input  logic [REG_W-1:0]  dst_len_i,
    input  logic [REG_W-1:0]  src_addr_i,
    input  logic [REG_W-1:0]  src_len_i,
    input  logic              irq_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic              paused,
    output logic [1:0]        cc,
    output logic [REG_W-1:0]  dst_addr_o,
    output logic [REG_W-1:0]  dst_len_o,
    output logic [REG_W-1:0]  src_addr_o,
    output logic [REG_W-1:0]  src_len_o
);

    localparam int HI_W = REG_W - ADDR_W;

    logic              load, dst_step, src_step, capture, from_src;
    logic              dst_empty, src_empty, destructive;
    logic [1:0]        cc_len;
    logic [ADDR_W-1:0] dst_addr_q, dst_len_q, src_addr_q, src_len_q;
    logic [HI_W-1:0]   dst_len_hi_q;
    logic [BYTE_W-1:0] pad_q;
    logic [BYTE_W-1:0] byte_q;
    logic              unused_hi;

    // Top bytes of the address images carry no meaning on input.
    assign unused_hi = ^{dst_addr_i[REG_W-1:ADDR_W], src_addr_i[REG_W-1:ADDR_W]};

    lbm_cursor #(.ADDR_W(ADDR_W)) u_dst (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (dst_step),
        .addr_i (dst_addr_i[ADDR_W-1:0]),
        .len_i  (dst_len_i[ADDR_W-1:0]),
        .addr_q (dst_addr_q),
        .len_q  (dst_len_q),
        .empty  (dst_empty)
    );

    lbm_cursor #(.ADDR_W(ADDR_W)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (src_step),
        .addr_i (src_addr_i[ADDR_W-1:0]),
        .len_i  (src_len_i[ADDR_W-1:0]),
        .addr_q (src_addr_q),
        .len_q  (src_len_q),
        .empty  (src_empty)
    );

    lbm_overlap #(.ADDR_W(ADDR_W)) u_ovl (
        .dst_addr    (dst_addr_q),
        .dst_len     (dst_len_q),
        .src_addr    (src_addr_q),
        .src_len     (src_len_q),
        .cc_len      (cc_len),
        .destructive (destructive)
    );

    lbm_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .irq_req     (irq_req),
        .mem_ack     (mem_ack),
        .dst_empty   (dst_empty),
        .src_empty   (src_empty),
        .destructive (destructive),
        .cc_len      (cc_len),
        .load        (load),
        .dst_step    (dst_step),
        .src_step    (src_step),
        .capture     (capture),
        .from_src    (from_src),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .busy        (busy),
        .done        (done),
        .paused      (paused),
        .cc          (cc)
    );

    // Keep the pass-through high bytes of the length images.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_len_hi_q <= '0;
            pad_q        <= '0;
        end else if (load) begin
            dst_len_hi_q <= dst_len_i[REG_W-1:ADDR_W];
            pad_q        <= src_len_i[REG_W-1:ADDR_W];
        end
    end

    // Hold the byte just read until its store completes.
    always_ff @(posedge clk) begin
        if (!rst_n)       byte_q <= '0;
        else if (capture) byte_q <= mem_rdata;
    end

    // Route the cursor of the current access and pick data or pad.
    always_comb begin
        mem_addr  = mem_we ? dst_addr_q : src_addr_q;
        mem_wdata = from_src ? byte_q : pad_q;
    end

    // Rebuild register images: addresses zero-extended, lengths keep top byte.
    always_comb begin
        dst_addr_o = {{HI_W{1'b0}}, dst_addr_q};
        src_addr_o = {{HI_W{1'b0}}, src_addr_q};
        dst_len_o  = {dst_len_hi_q, dst_len_q};
        src_len_o  = {pad_q, src_len_q};
    end

endmodule

// File: rtl/lbm_engine_sva.sv
// Property checker for lbm_engine, attached by bind below.
// Assumes: observes ports only, plus an access counter of its own.
module lbm_engine_sva #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic              paused,
    input logic [1:0]        cc,
    input logic [REG_W-1:0]  dst_addr_o,
    input logic [REG_W-1:0]  dst_len_o,
    input logic [REG_W-1:0]  src_addr_o
);

    logic [15:0] acc_seen;

    // Count memory accesses since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                  acc_seen <= '0;
        else if (start && !busy)     acc_seen <= '0;
        else if (mem_req && mem_ack) acc_seen <= acc_seen + 16'd1;
    end

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_store_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=>
            dst_len_o[ADDR_W-1:0] == $past(dst_len_o[ADDR_W-1:0]) - ADDR_W'(1));

    assert_addr_hi_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || paused) |->
            (dst_addr_o[REG_W-1:ADDR_W] == '0) && (src_addr_o[REG_W-1:ADDR_W] == '0));

    assert_finish_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && (cc != 2'd3) |-> dst_len_o[ADDR_W-1:0] == '0);

    assert_overlap_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done && (cc == 2'd3) |-> acc_seen == '0);

    assert_pause_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> (dst_len_o[ADDR_W-1:0] != '0) && !done);

endmodule

bind lbm_engine lbm_engine_sva #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .done       (done),
    .paused     (paused),
    .cc         (cc),
    .dst_addr_o (dst_addr_o),
    .dst_len_o  (dst_len_o),
    .src_addr_o (src_addr_o)
);

// File: tb/lbm_engine_tb.sv
module lbm_engine_tb;

    typedef struct packed {
        logic [23:0] d;
        logic [23:0] dl;
        logic [23:0] s;
        logic [23:0] sl;
        logic [7:0]  pad;
        logic [1:0]  cc;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{24'h000100, 24'd8,  24'h000200, 24'd8,  8'h5A, 2'd0, 4'd2},
        '{24'h000100, 24'd4,  24'h000200, 24'd10, 8'h5A, 2'd1, 4'd2},
        '{24'h000100, 24'd12, 24'h000200, 24'd5,  8'hC3, 2'd2, 4'd7},
        '{24'h000200, 24'd6,  24'h000200, 24'd6,  8'h11, 2'd0, 4'd4},
        '{24'h000101, 24'd6,  24'h000100, 24'd6,  8'h22, 2'd3, 4'd3},
        '{24'h000101, 24'd6,  24'h000100, 24'd1,  8'h33, 2'd2, 4'd4},
        '{24'h000100, 24'd5,  24'h000102, 24'd5,  8'h44, 2'd0, 4'd4},
        '{24'h000001, 24'd6,  24'hFFFFFE, 24'd6,  8'h55, 2'd3, 4'd5},
        '{24'h000010, 24'd4,  24'hFFFFFE, 24'd4,  8'h66, 2'd0, 4'd5},
        '{24'hFFFFFD, 24'd5,  24'h000300, 24'd3,  8'h77, 2'd2, 4'd7},
        '{24'h000100, 24'd0,  24'h000200, 24'd3,  8'h88, 2'd1, 4'd6},
        '{24'h000100, 24'd0,  24'h000200, 24'd0,  8'h99, 2'd0, 4'd6},
        '{24'h000100, 24'd3,  24'h000200, 24'd0,  8'hE7, 2'd2, 4'd7},
        '{24'hFFFFFE, 24'd4,  24'h000001, 24'd4,  8'hAA, 2'd0, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dst_addr_i = '0, dst_len_i = '0, src_addr_i = '0, src_len_i = '0;
    logic        irq_req = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done, paused;
    logic [1:0]  cc;
    logic [31:0] dst_addr_o, dst_len_o, src_addr_o, src_len_o;

    logic [7:0]  mem [0:1023];
    logic [7:0]  pre [0:1023];
    logic [7:0]  expm [0:1023];
    logic        fill = 1'b0;
    logic [7:0]  seed = '0;
    int          rd_cnt, wr_cnt;
    int          checks = 0, errors = 0, cycles = 0;

    always #5 clk = ~clk;

    lbm_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dst_addr_i(dst_addr_i), .dst_len_i(dst_len_i),
        .src_addr_i(src_addr_i), .src_len_i(src_len_i),
        .irq_req(irq_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .paused(paused), .cc(cc),
        .dst_addr_o(dst_addr_o), .dst_len_o(dst_len_o),
        .src_addr_o(src_addr_o), .src_len_o(src_len_o)
    );

    // Memory model: one-cycle acknowledge, aliased onto 1024 bytes.
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack;
        if (fill) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'(i * 13 + int'(seed) * 29 + 7);
        end else if (mem_req && mem_ack && mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
        end
        if (start) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else if (mem_req && mem_ack) begin
            if (mem_we) wr_cnt <= wr_cnt + 1;
            else        rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            finish_run();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tagname(logic [3:0] t);
        case (t)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic refill(logic [7:0] sd);
        @(negedge clk); seed = sd; fill = 1'b1;
        @(negedge clk); fill = 1'b0;
        for (int i = 0; i < 1024; i++) pre[i] = mem[i];
    endtask

    // Start a move; optionally raise irq at start or after N stores.
    task automatic run(logic [31:0] da, logic [31:0] dl, logic [31:0] sa,
                       logic [31:0] sl, bit irq0, int irq_after);
        @(negedge clk);
        dst_addr_i = da; dst_len_i = dl; src_addr_i = sa; src_len_i = sl;
        irq_req = irq0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int w = 0; w < 20000; w++) begin
            if (done || paused) break;
            if (irq_after >= 0 && wr_cnt == irq_after) irq_req = 1'b1;
            @(negedge clk);
        end
        irq_req = 1'b0;
    endtask

    task automatic build_exp(logic [23:0] d, logic [23:0] dl, logic [23:0] s,
                             logic [23:0] sl, logic [7:0] pad, bit moved);
        for (int i = 0; i < 1024; i++) expm[i] = pre[i];
        if (moved) begin
            for (int i = 0; i < int'(dl); i++) begin
                logic [23:0] da = d + 24'(i);
                logic [23:0] sa = s + 24'(i);
                expm[da[9:0]] = (i < int'(sl)) ? pre[sa[9:0]] : pad;
            end
        end
    endtask

    task automatic chk_mem(string req);
        int bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) bad++;
        chk(req, 32'(bad), 32'd0);
    endtask

    initial begin
        // Reset state (R11: idle, no request).
        repeat (3) @(negedge clk);
        chk("R11 reset busy", {31'd0, busy}, 32'd0);
        chk("R11 reset req", {31'd0, mem_req}, 32'd0);
        chk("R8 reset done", {30'd0, done, paused}, 32'd0);
        rst_n = 1'b1;

        // Vector table walk.
        for (int k = 0; k < NV; k++) begin
            vec_t v = VEC[k];
            logic [23:0] span = (v.dl < v.sl) ? v.dl : v.sl;
            bool_ovl: begin end
            refill(8'(k + 1));
            run({8'hAB, v.d}, {8'h11, v.dl}, {8'hCD, v.s}, {v.pad, v.sl}, 1'b0, -1);
            chk({tagname(v.tag), " R2 cc"}, {30'd0, cc}, {30'd0, v.cc});
            chk("R8 done", {31'd0, done}, 32'd1);
            if (v.cc == 2'd3) begin
                chk("R3 dst addr", dst_addr_o, {8'h00, v.d});
                chk("R3 dst len", dst_len_o, {8'h11, v.dl});
                chk("R3 src addr", src_addr_o, {8'h00, v.s});
                chk("R3 src len", src_len_o, {v.pad, v.sl});
                chk("R3 accesses", 32'(rd_cnt + wr_cnt), 32'd0);
                build_exp(v.d, v.dl, v.s, v.sl, v.pad, 1'b0);
            end else begin
                chk("R1 R8 dst addr", dst_addr_o, {8'h00, v.d + v.dl});
                chk("R1 R8 dst len", dst_len_o, {8'h11, 24'd0});
                chk("R1 R8 src addr", src_addr_o, {8'h00, v.s + span});
                chk("R1 R8 src len", src_len_o, {v.pad, v.sl - span});
                chk("R7 reads", 32'(rd_cnt), 32'(span));
                chk("R6 R7 writes", 32'(wr_cnt), 32'(v.dl));
                build_exp(v.d, v.dl, v.s, v.sl, v.pad, 1'b1);
            end
            chk_mem({tagname(v.tag), " memory"});
        end

        // R9: irq held from start stops after exactly one store.
        refill(8'h40);
        run({8'hAB, 24'h000100}, {8'h11, 24'd10}, {8'hCD, 24'h000200}, {8'h3C, 24'd10}, 1'b1, -1);
        chk("R9 paused", {30'd0, paused, done}, 32'd2);
        chk("R9 one store", 32'(wr_cnt), 32'd1);
        chk("R9 dst len", dst_len_o, {8'h11, 24'd9});
        chk("R9 src addr", src_addr_o, 32'h0000_0201);
        run(dst_addr_o, dst_len_o, src_addr_o, src_len_o, 1'b0, -1);
        chk("R9 resume done", {31'd0, done}, 32'd1);
        chk("R9 resume dst addr", dst_addr_o, 32'h0000_010A);
        chk("R9 resume src len", src_len_o, {8'h3C, 24'd0});
        build_exp(24'h000100, 24'd10, 24'h000200, 24'd10, 8'h3C, 1'b1);
        chk_mem("R9 resume memory");

        // R10: interrupt taken in the pad phase after three stores.
        refill(8'h50);
        run({8'hAB, 24'h000300}, {8'h11, 24'd8}, {8'hCD, 24'h000100}, {8'hB6, 24'd2}, 1'b0, 3);
        chk("R10 paused", {30'd0, paused, done}, 32'd2);
        chk("R10 stores", 32'(wr_cnt), 32'd3);
        chk("R10 src len zero", src_len_o, {8'hB6, 24'd0});
        chk("R10 src addr full", src_addr_o, 32'h0000_0102);
        chk("R10 dst addr", dst_addr_o, 32'h0000_0303);
        chk("R10 dst len", dst_len_o, {8'h11, 24'd5});
        run(dst_addr_o, dst_len_o, src_addr_o, src_len_o, 1'b0, -1);
        chk("R10 resume cc", {30'd0, cc}, 32'd2);
        chk("R10 resume reads", 32'(rd_cnt), 32'd0);
        chk("R10 resume dst len", dst_len_o, {8'h11, 24'd0});
        build_exp(24'h000300, 24'd8, 24'h000100, 24'd2, 8'hB6, 1'b1);
        chk_mem("R10 resume memory");

        finish_run();
    end

endmodule